// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block is a scratchpad memory split into 32 equal banks that serves one request per cycle on behalf of a whole group of 32 lanes. Each lane brings its own valid bit, byte address, read/write flag and write data. The block works out which bank and which row every lane touches. It then schedules the lanes into passes, with one access per bank per pass. A request whose active lanes all fall in different banks finishes in a single pass. Lanes that want different words of the same bank are spread over successive passes. Lanes that want the same word are served together in one access, and for reads the word is shared among them.

A mode input chooses a 4-byte or an 8-byte bank word. Each bank row holds 64 bits. In 4-byte mode only the lower half of a row is read and written. Once a request is accepted, `busy` stays high until the last pass. The block then raises `done` for one cycle and presents every lane's read data together with the number of passes used. The caller can read the conflict degree of each request from that pass count.

Top module: `spad_serializer`

## Requirements
- R1: After reset `busy`, `done`, `pass_count` and all of `rd_data` are zero.
- R2: In 4-byte mode (`wide_banks`=0) a lane's bank is address bits [6:2] and its row is bits [11:7]. In 8-byte mode the bank is bits [7:3] and the row is bits [11:8]. Address bits below the bank word size are ignored.
- R3: When every active lane hits a different bank, or lanes in a bank hit one word, the request uses exactly one pass.
- R4: Within each bank, each pass serves the word of the lowest-numbered unserved lane in that bank, together with every unserved lane that wants that word. The pass count equals the largest number of distinct words that any one bank is asked for.
- R5: Any number of lanes reading the same word are served in one access and all receive that word.
- R6: When several lanes write one word in the same pass, the highest-numbered lane's data is stored. A read in a pass returns the content from before that pass's writes.
- R7: A request is accepted on a clock edge where `req_valid` is high and `busy` is low. `busy` is high in the cycles after acceptance until the last pass. `req_valid` is ignored while `busy` is high.
- R8: With P passes (P≥1), `busy` is high for P cycles after the accepting edge, and `done` is high for exactly the following cycle. In that cycle `busy` is low and `pass_count` equals P.
- R9: A lane whose valid bit is clear returns zero read data. A request with no valid lanes returns `done` after one busy cycle with `pass_count`=0.
- R10: In 4-byte mode a write changes only bits [31:0] of the bank row, and a read returns bits [31:0] with the upper 32 bits zero. In 8-byte mode all 64 bits are written and read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Offer a request this cycle |
| wide_banks | input | 1 | 0: 4-byte bank word, 1: 8-byte bank word |
| lane_valid | input | 32 | Per-lane active bit |
| lane_write | input | 32 | Per-lane write (1) or read (0) |
| lane_addr | input | 384 | Per-lane 12-bit byte address, lane i at bits [12i+11:12i] |
| lane_wdata | input | 2048 | Per-lane 64-bit write data, lane i at bits [64i+63:64i] |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| pass_count | output | 6 | Passes used by the last completed request |
| rd_data | output | 2048 | Per-lane read data, same packing as write data |

## Verification
Once the accepting edge has passed, `busy` is due at the next sample and must stay high for exactly the number of passes the bench model predicts. `done`, `pass_count` and all read data are due one cycle after the last busy cycle. The bench drives on the falling edge and samples on the falling edge. It compares `busy` and `done` with the model's cycle-by-cycle expectation at every sample, and compares count and data in the predicted `done` cycle. During one long conflicted request the bench keeps offering a different request. It then reads back the affected words to confirm that the offer was dropped.

// File: rtl/spad_pkg.sv
package spad_pkg;
    typedef enum logic {
        BANK_4B = 1'b0,
        BANK_8B = 1'b1
    } bank_width_e;

    localparam int unsigned NARROW_SHIFT = 2;
    localparam int unsigned WIDE_SHIFT   = 3;
endpackage

// File: rtl/spad_bank_map.sv
module spad_bank_map #(
    parameter int unsigned LANES = 32,
    parameter int unsigned BB    = 5,
    parameter int unsigned AW    = 12,
    parameter int unsigned ROWW  = AW - 2 - BB
) (
    input  spad_pkg::bank_width_e           mode,
    input  logic [LANES-1:0][AW-1:0]        addr,
    output logic [LANES-1:0][BB-1:0]        bank,
    output logic [LANES-1:0][ROWW-1:0]      row
);
    import spad_pkg::*;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            if (mode == BANK_8B) begin
                bank[i] = addr[i][WIDE_SHIFT +: BB];
                row[i]  = {1'b0, addr[i][AW-1:WIDE_SHIFT+BB]};
            end else begin
                bank[i] = addr[i][NARROW_SHIFT +: BB];
                row[i]  = addr[i][AW-1:NARROW_SHIFT+BB];
            end
        end
    end
endmodule

// File: rtl/spad_pass_select.sv
module spad_pass_select #(
    parameter int unsigned LANES = 32,
    parameter int unsigned BB    = 5,
    parameter int unsigned ROWW  = 5
) (
    input  logic [LANES-1:0]           pending,
    input  logic [LANES-1:0][BB-1:0]   bank,
    input  logic [LANES-1:0][ROWW-1:0] row,
    output logic [LANES-1:0]           served
);
    logic [LANES-1:0] leader;

    // a leader is the lowest pending lane of its bank
    for (genvar i = 0; i < LANES; i++) begin : g_lead
        always_comb begin
            leader[i] = pending[i];
            for (int j = 0; j < i; j++) begin
                if (pending[j] && bank[j] == bank[i]) leader[i] = 1'b0;
            end
        end
    end

    // a lane is served when a leader wants the same bank and row
    for (genvar i = 0; i < LANES; i++) begin : g_srv
        always_comb begin
            served[i] = 1'b0;
            for (int j = 0; j < LANES; j++) begin
                if (leader[j] && bank[j] == bank[i] && row[j] == row[i])
                    served[i] = pending[i];
            end
        end
    end
endmodule

// File: rtl/spad_bank_store.sv
module spad_bank_store #(
    parameter int unsigned LANES = 32,
    parameter int unsigned BANKS = 32,
    parameter int unsigned DW    = 64,
    parameter int unsigned ROWW  = 5,
    localparam int unsigned BB   = $clog2(BANKS),
    localparam int unsigned ROWS = 1 << ROWW,
    localparam int unsigned HALF = DW / 2
) (
    input  logic                        clk,
    input  spad_pkg::bank_width_e       mode,
    input  logic [LANES-1:0]            served,
    input  logic [LANES-1:0]            wr,
    input  logic [LANES-1:0][BB-1:0]    bank,
    input  logic [LANES-1:0][ROWW-1:0]  row,
    input  logic [LANES-1:0][DW-1:0]    wdata,
    output logic [LANES-1:0][DW-1:0]    rdata
);
    import spad_pkg::*;

    logic [DW-1:0]   mem_q [BANKS][ROWS];
    logic [BANKS-1:0]           we_d;
    logic [BANKS-1:0][ROWW-1:0] wrow_d;
    logic [BANKS-1:0][DW-1:0]   wdat_d;

    // ascending lane order: the highest writing lane of a bank wins
    always_comb begin
        we_d   = '0;
        wrow_d = '0;
        wdat_d = '0;
        for (int i = 0; i < LANES; i++) begin
            if (served[i] && wr[i]) begin
                we_d[bank[i]]   = 1'b1;
                wrow_d[bank[i]] = row[i];
                wdat_d[bank[i]] = wdata[i];
            end
        end
    end

    // reads see the content before this pass's writes
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            if (mode == BANK_8B) rdata[i] = mem_q[bank[i]][row[i]];
            else                 rdata[i] = {{HALF{1'b0}}, mem_q[bank[i]][row[i]][HALF-1:0]};
        end
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (we_d[b]) begin
                if (mode == BANK_8B) mem_q[b][wrow_d[b]] <= wdat_d[b];
                else mem_q[b][wrow_d[b]] <= {mem_q[b][wrow_d[b]][DW-1:HALF], wdat_d[b][HALF-1:0]};
            end
        end
    end
endmodule

// File: rtl/spad_serializer.sv
module spad_serializer #(
    parameter int unsigned LANES = 32,
    parameter int unsigned BANKS = 32,
    parameter int unsigned AW    = 12,
    parameter int unsigned DW    = 64,
    localparam int unsigned BB   = $clog2(BANKS),
    localparam int unsigned ROWW = AW - 2 - BB,
    localparam int unsigned CW   = $clog2(LANES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  wide_banks,
    input  logic [LANES-1:0]      lane_valid,
    input  logic [LANES-1:0]      lane_write,
    input  logic [LANES*AW-1:0]   lane_addr,
    input  logic [LANES*DW-1:0]   lane_wdata,
    output logic                  busy,
    output logic                  done,
    output logic [CW-1:0]         pass_count,
    output logic [LANES*DW-1:0]   rd_data
);
    import spad_pkg::*;

    typedef struct packed {
        logic                       busy;
        logic                       done;
        logic [CW-1:0]              cnt;
        logic [LANES-1:0]           pend;
        bank_width_e                mode;
        logic [LANES-1:0]           wr;
        logic [LANES-1:0][AW-1:0]   addr;
        logic [LANES-1:0][DW-1:0]   wdat;
        logic [LANES-1:0][DW-1:0]   rd;
    } state_t;

    state_t st_d, st_q;

    logic [LANES-1:0][BB-1:0]   bank_w;
    logic [LANES-1:0][ROWW-1:0] row_w;
    logic [LANES-1:0]           served_w;
    logic [LANES-1:0][DW-1:0]   rdata_w;

    spad_bank_map #(.LANES(LANES), .BB(BB), .AW(AW), .ROWW(ROWW)) i_map (
        .mode (st_q.mode),
        .addr (st_q.addr),
        .bank (bank_w),
        .row  (row_w)
    );

    spad_pass_select #(.LANES(LANES), .BB(BB), .ROWW(ROWW)) i_sel (
        .pending (st_q.busy ? st_q.pend : '0),
        .bank    (bank_w),
        .row     (row_w),
        .served  (served_w)
    );

    spad_bank_store #(.LANES(LANES), .BANKS(BANKS), .DW(DW), .ROWW(ROWW)) i_store (
        .clk    (clk),
        .mode   (st_q.mode),
        .served (served_w),
        .wr     (st_q.wr),
        .bank   (bank_w),
        .row    (row_w),
        .wdata  (st_q.wdat),
        .rdata  (rdata_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (req_valid) begin
                st_d.busy = 1'b1;
                st_d.cnt  = '0;
                st_d.pend = lane_valid;
                st_d.mode = bank_width_e'(wide_banks);
                st_d.wr   = lane_write;
                st_d.addr = lane_addr;
                st_d.wdat = lane_wdata;
                st_d.rd   = '0;
            end
        end else if (st_q.pend == '0) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
        end else begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.pend = st_q.pend & ~served_w;
            for (int i = 0; i < LANES; i++) begin
                if (served_w[i]) st_d.rd[i] = rdata_w[i];
            end
            if (st_d.pend == '0) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy       = st_q.busy;
    assign done       = st_q.done;
    assign pass_count = st_q.cnt;
    assign rd_data    = st_q.rd;

    a_r4_progress: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.pend != '0) |-> served_w != '0);
    a_r4_served_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (served_w & ~st_q.pend) == '0);
    a_r4_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.pend != '0) |=> $countones(st_q.pend) < $past($countones(st_q.pend)));
    a_r7_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && (st_q.pend & ~served_w) != '0) |=> busy);
    a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/test_spad_serializer.sv
`timescale 1ns/1ps
module test_spad_serializer;
    localparam int L = 32;
    localparam int AW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic wide_banks = 1'b0;
    logic [L-1:0] lane_valid = '0;
    logic [L-1:0] lane_write = '0;
    logic [L*AW-1:0] lane_addr = '0;
    logic [L*64-1:0] lane_wdata = '0;
    logic busy, done;
    logic [5:0] pass_count;
    logic [L*64-1:0] rd_data;

    spad_serializer i_spad_serializer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .wide_banks(wide_banks),
        .lane_valid(lane_valid), .lane_write(lane_write), .lane_addr(lane_addr),
        .lane_wdata(lane_wdata), .busy(busy), .done(done), .pass_count(pass_count),
        .rd_data(rd_data)
    );

    always #2.5 clk = ~clk;

    int total = 0;
    int bad = 0;

    logic [63:0] mm [32][32];
    logic [AW-1:0] s_addr [L];
    logic [63:0]   s_wd   [L];
    logic          s_wr   [L];
    logic          s_v    [L];
    logic [63:0]   exp_rd [L];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clr();
        for (int i = 0; i < L; i++) begin
            s_addr[i] = '0; s_wd[i] = '0; s_wr[i] = 1'b0; s_v[i] = 1'b0;
        end
    endtask

    function automatic int bank_of(input bit wide, input logic [AW-1:0] a);
        return wide ? int'(a[7:3]) : int'(a[6:2]);
    endfunction
    function automatic int row_of(input bit wide, input logic [AW-1:0] a);
        return wide ? int'(a[11:8]) : int'(a[11:7]);
    endfunction

    // reference: predicts pass count and read data, updates model memory
    task automatic model(input bit wide, output int passes);
        logic [L-1:0] pend, srv;
        int lead, b, r;
        passes = 0;
        for (int i = 0; i < L; i++) begin
            pend[i] = s_v[i];
            exp_rd[i] = '0;
        end
        while (pend != '0) begin
            passes++;
            srv = '0;
            for (int bk = 0; bk < 32; bk++) begin
                lead = -1;
                for (int i = 0; i < L; i++)
                    if (lead < 0 && pend[i] && bank_of(wide, s_addr[i]) == bk) lead = i;
                if (lead >= 0)
                    for (int i = 0; i < L; i++)
                        if (pend[i] && bank_of(wide, s_addr[i]) == bk &&
                            row_of(wide, s_addr[i]) == row_of(wide, s_addr[lead])) srv[i] = 1'b1;
            end
            for (int i = 0; i < L; i++) if (srv[i] && !s_wr[i]) begin
                b = bank_of(wide, s_addr[i]); r = row_of(wide, s_addr[i]);
                exp_rd[i] = wide ? mm[b][r] : {32'h0, mm[b][r][31:0]};
            end
            for (int i = 0; i < L; i++) if (srv[i] && s_wr[i]) begin
                b = bank_of(wide, s_addr[i]); r = row_of(wide, s_addr[i]);
                if (wide) mm[b][r] = s_wd[i];
                else      mm[b][r] = {mm[b][r][63:32], s_wd[i][31:0]};
            end
            for (int i = 0; i < L; i++) if (srv[i] && s_wr[i]) exp_rd[i] = (wide ? mm[bank_of(wide, s_addr[i])][row_of(wide, s_addr[i])] : exp_rd[i]);
            pend &= ~srv;
        end
    endtask

    task automatic drive(input bit wide);
        wide_banks = wide;
        for (int i = 0; i < L; i++) begin
            lane_valid[i] = s_v[i];
            lane_write[i] = s_wr[i];
            lane_addr[i*AW +: AW] = s_addr[i];
            lane_wdata[i*64 +: 64] = s_wd[i];
        end
    endtask

    // inject: offer a junk write request while busy (must be ignored, R7)
    task automatic run(input bit wide, input string tag, input int want_p, input bit inject);
        int p, nb;
        model(wide, p);
        @(negedge clk);
        chk(!busy && !done, {tag, " R8 idle before"}, {62'h0, busy, done}, 64'h0);
        if (want_p >= 0) chk(p == want_p, {tag, " model"}, 64'(p), 64'(want_p));
        drive(wide);
        req_valid = 1'b1;
        nb = (p < 1) ? 1 : p;
        for (int s = 0; s < nb; s++) begin
            @(negedge clk);
            chk(busy && !done, {tag, " R7 busy"}, {62'h0, busy, done}, 64'h2);
            if (inject && s < nb - 1) begin
                wide_banks = 1'b1;
                lane_valid = '1;
                lane_write = '1;
                lane_addr  = '0;
                lane_wdata = {L{64'hBAD0_BAD0_BAD0_BAD0}};
                req_valid = 1'b1;
            end else req_valid = 1'b0;
        end
        @(negedge clk);
        chk(!busy && done, {tag, " R8 done"}, {62'h0, busy, done}, 64'h1);
        chk(pass_count == 6'(p), {tag, " R8 pass_count"}, 64'(pass_count), 64'(p));
        for (int i = 0; i < L; i++) begin
            if (!s_wr[i])
                chk(rd_data[i*64 +: 64] == exp_rd[i], {tag, " R9 rd_data"}, rd_data[i*64 +: 64], exp_rd[i]);
        end
        req_valid = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        bad++;
        $display("FAIL watchdog R8 actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int b = 0; b < 32; b++) for (int r = 0; r < 32; r++) mm[b][r] = '0;
        clr();
        repeat (3) @(negedge clk);
        chk(!busy && !done && pass_count == 0 && rd_data == '0, "R1 reset", {62'h0, busy, done}, 64'h0);
        rst_n = 1'b1;

        // R2 R3: wide writes, one per bank
        clr();
        for (int i = 0; i < L; i++) begin
            s_v[i] = 1'b1; s_wr[i] = 1'b1; s_addr[i] = AW'(i * 8);
            s_wd[i] = {32'hC0DE_0000 + 32'(i), 32'h0000_1000 + 32'(i)};
        end
        run(1'b1, "R3 wide write", 1, 1'b0);

        // R2: byte offset ignored, R3 single pass read
        clr();
        for (int i = 0; i < L; i++) begin
            s_v[i] = 1'b1; s_addr[i] = AW'(i * 8 + (i % 8));
        end
        run(1'b1, "R2 offset read", 1, 1'b0);

        // R5 broadcast
        clr();
        for (int i = 0; i < L; i++) begin s_v[i] = 1'b1; s_addr[i] = 12'h010; end
        run(1'b1, "R5 broadcast", 1, 1'b0);

        // R4 R7: 32-way conflict with injected offer while busy
        clr();
        for (int i = 0; i < L; i++) begin
            s_v[i] = 1'b1; s_wr[i] = 1'b1; s_addr[i] = AW'(i * 128 + 4);
            s_wd[i] = {32'hFFFF_FFFF, 32'h5000_0000 + 32'(i)};
        end
        run(1'b0, "R4 32way write", 32, 1'b1);

        // R4 R10: read back, narrow zero-extended; also proves R7 ignore
        clr();
        for (int i = 0; i < L; i++) begin s_v[i] = 1'b1; s_addr[i] = AW'(i * 128 + 4); end
        run(1'b0, "R10 32way read", 32, 1'b0);

        // R7: wide words untouched by the ignored offer
        clr();
        for (int i = 0; i < L; i++) begin s_v[i] = 1'b1; s_addr[i] = AW'(i * 8); end
        run(1'b1, "R7 ignored offer", 1, 1'b0);

        // R4: two-way conflict write then read
        clr();
        for (int i = 0; i < L; i++) begin
            s_v[i] = 1'b1; s_wr[i] = 1'b1; s_addr[i] = AW'((i % 16) * 4 + (i / 16) * 128 + 512);
            s_wd[i] = 64'(32'h7700_0000 + 32'(i));
        end
        run(1'b0, "R4 2way write", 2, 1'b0);
        for (int i = 0; i < L; i++) s_wr[i] = 1'b0;
        run(1'b0, "R4 2way read", 2, 1'b0);

        // R6: same-word writes, highest lane wins; read in same pass sees old value
        clr();
        s_v[3] = 1; s_wr[3] = 1; s_addr[3] = 12'h040; s_wd[3] = 64'h3333;
        s_v[9] = 1; s_wr[9] = 1; s_addr[9] = 12'h044; s_wd[9] = 64'h9999;
        s_v[20] = 1; s_wr[20] = 1; s_addr[20] = 12'h040; s_wd[20] = 64'h2020_2020;
        s_v[5] = 1; s_addr[5] = 12'h040;
        s_v[7] = 1; s_wr[7] = 1; s_addr[7] = 12'h140; s_wd[7] = 64'h7777;
        run(1'b1, "R6 collide", 2, 1'b0);
        clr();
        s_v[0] = 1; s_addr[0] = 12'h040;
        s_v[1] = 1; s_addr[1] = 12'h140;
        run(1'b1, "R6 readback", 2, 1'b0);
        chk(rd_data[63:0] == 64'h2020_2020, "R6 highest lane stored", rd_data[63:0], 64'h2020_2020);

        // R9: empty request and single valid lane
        clr();
        run(1'b1, "R9 empty", 0, 1'b0);
        clr();
        s_v[4] = 1; s_addr[4] = 12'h020;
        run(1'b1, "R9 one lane", 1, 1'b0);
        chk(rd_data[0 +: 64] == 64'h0, "R9 inactive lane zero", rd_data[0 +: 64], 64'h0);

        // R10: narrow write keeps upper half
        clr();
        s_v[0] = 1; s_wr[0] = 1; s_addr[0] = 12'h008; s_wd[0] = 64'h1234_5678_DEAD_BEEF;
        run(1'b0, "R10 narrow write", 1, 1'b0);
        clr();
        s_v[0] = 1; s_addr[0] = 12'h010;
        run(1'b1, "R10 wide readback", 1, 1'b0);
        chk(rd_data[63:0] == 64'hC0DE_0002_DEAD_BEEF, "R10 upper kept", rd_data[63:0], 64'hC0DE_0002_DEAD_BEEF);

        @(negedge clk);
        chk(!busy && !done, "R8 final idle", {62'h0, busy, done}, 64'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule